// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block keeps the four condition flags of a 32-bit datapath: negative, zero, carry and overflow. Each cycle it reads the ALU result, the carry or borrow out of the arithmetic unit, the sign bits of the two operands and of the result, and the carry out of the shifter. A 2-bit operation class tells it how each flag is formed. When the update enable is high, the new flags are loaded into the flag register on the rising clock edge. When the enable is low, the register keeps its contents.

The register is the current flag state. Carry and overflow are held whenever the operation class says they are not affected. The flags are driven out as a 4-bit field with N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.

Top module: `flag_nzcv_gen`

## Requirements
- R1: The flag field has N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. On an update, N becomes bit 31 of `result`.
- R2: On an update, Z becomes 1 when all 32 bits of `result` are zero, and 0 otherwise.
- R3: The add class is code 2'b00. On an update of this class, C becomes `arith_co`, the unsigned carry out of bit 31.
- R4: The subtract class is code 2'b01, and for it `arith_co` carries the borrow. On an update of this class, C becomes the inverse of `arith_co`: 0 on a borrow, 1 without one.
- R5: The shifted-logical class is code 2'b10. On an update of this class, C becomes `shift_co`, the last bit shifted out.
- R6: The plain-logical class is code 2'b11. On an update of this class, C keeps its previous value.
- R7: On an add update, V becomes 1 exactly when the operand signs are equal and the result sign differs from them.
- R8: On a subtract update, V becomes 1 exactly when the operand signs differ and the result sign differs from the first operand's sign.
- R9: On an update of class 2'b10 or 2'b11, V keeps its previous value.
- R10: While `upd_en` is low, all four flags keep their values, whatever the operation class and data inputs are.
- R11: When `rst_n` is low at a rising clock edge, all four flags are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flags change on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Loads the flag register when high |
| op_cls | input | 2 | Operation class: 00 add, 01 subtract, 10 shifted-logical, 11 plain-logical |
| result | input | 32 | ALU result |
| arith_co | input | 1 | Carry out for add; borrow out for subtract |
| sign_a | input | 1 | Sign bit of the first operand |
| sign_b | input | 1 | Sign bit of the second operand |
| sign_r | input | 1 | Sign bit of the arithmetic result |
| shift_co | input | 1 | Last bit shifted out by the shifter |
| flags_q | output | 4 | Current flags {N, Z, C, V} |

## Verification
Each flag is a single register bit that is fed straight back into its own next-value logic. A wrong value is therefore visible on `flags_q` one edge after the update that causes it. It also stays there through every later cycle in which that flag is held: idle cycles, plain-logical carry and logical overflow. A fault in how a held flag is fed back shows up only later, when a hold follows a different update. For this reason the bench places hold cycles right after every update class and compares every cycle.

// File: rtl/flag_nzcv_pkg.sv
// Package: shared encodings for the condition flag generator.
// Assumes flag fields are packed N,Z,C,V from MSB to LSB.
package flag_nzcv_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_SHLOG = 2'b10,
        OPC_LOG   = 2'b11
    } op_cls_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

endpackage

// File: rtl/flag_zero_detect.sv
// Module: flag_zero_detect
// Reports whether a data word is all zero. It ORs fixed-width lanes first,
// then ORs the lane results, so the logic depth is set by LANE_W.
// Assumes DATA_W >= 1 and LANE_W >= 1; the last lane may be narrower.
module flag_zero_detect #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic              is_zero
);
    localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W;

    logic [LANES-1:0] lane_any;

    // One OR reduction per lane, clipped at the top of the word.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LO = i * LANE_W;
        localparam int HI = (LO + LANE_W - 1 < DATA_W) ? (LO + LANE_W - 1) : (DATA_W - 1);
        assign lane_any[i] = |data[HI:LO];
    end

    // Final stage: the word is zero when no lane has a set bit.
    always_comb begin
        is_zero = ~(|lane_any);
    end

endmodule

// File: rtl/flag_carry_sel.sv
// Module: flag_carry_sel
// Chooses the next carry flag from the operation class.
// Assumes arith_co is a carry for add and a borrow for subtract.
module flag_carry_sel
    import flag_nzcv_pkg::*;
(
    input  op_cls_e op_cls,
    input  logic    arith_co,
    input  logic    shift_co,
    input  logic    c_cur,
    output logic    c_nxt
);
    // Carry source per class; plain-logical keeps the held value.
    always_comb begin
        unique case (op_cls)
            OPC_ADD:   c_nxt = arith_co;
            OPC_SUB:   c_nxt = ~arith_co;
            OPC_SHLOG: c_nxt = shift_co;
            default:   c_nxt = c_cur;
        endcase
    end

endmodule

// File: rtl/flag_overflow_det.sv
// Module: flag_overflow_det
// Works out the next overflow flag from sign bits only.
// Assumes sign_r is the sign of the add or subtract result.
module flag_overflow_det
    import flag_nzcv_pkg::*;
(
    input  op_cls_e op_cls,
    input  logic    sign_a,
    input  logic    sign_b,
    input  logic    sign_r,
    input  logic    v_cur,
    output logic    v_nxt
);
    logic flip;

    // The result sign has moved away from the first operand's sign.
    always_comb begin
        flip = sign_r ^ sign_a;
    end

    // Add needs equal operand signs, subtract needs unequal ones; logical classes hold.
    always_comb begin
        unique case (op_cls)
            OPC_ADD: v_nxt = flip & ~(sign_a ^ sign_b);
            OPC_SUB: v_nxt = flip &  (sign_a ^ sign_b);
            default: v_nxt = v_cur;
        endcase
    end

endmodule

// File: rtl/flag_nzcv_gen.sv
// Module: flag_nzcv_gen (top)
// Holds the N, Z, C and V flags and loads them from the ALU outputs when
// upd_en is high. Assumes the inputs are stable around the rising edge of
// clk. The reset is synchronous and active low.
module flag_nzcv_gen
    import flag_nzcv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_cls,
    input  logic [DATA_W-1:0] result,
    input  logic              arith_co,
    input  logic              sign_a,
    input  logic              sign_b,
    input  logic              sign_r,
    input  logic              shift_co,
    output logic [FLAG_W-1:0] flags_q
);
    localparam int MSB = DATA_W - 1;

    flags_t  cur_q;
    flags_t  nxt;
    op_cls_e cls;
    logic    zero_w;
    logic    c_w;
    logic    v_w;

    // Turn the raw class bits into the enum.
    always_comb begin
        cls = op_cls_e'(op_cls);
    end

    flag_zero_detect #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_zero (
        .data    (result),
        .is_zero (zero_w)
    );

    flag_carry_sel u_carry (
        .op_cls   (cls),
        .arith_co (arith_co),
        .shift_co (shift_co),
        .c_cur    (cur_q.c),
        .c_nxt    (c_w)
    );

    flag_overflow_det u_ovf (
        .op_cls (cls),
        .sign_a (sign_a),
        .sign_b (sign_b),
        .sign_r (sign_r),
        .v_cur  (cur_q.v),
        .v_nxt  (v_w)
    );

    // Collect the candidate flag word.
    always_comb begin
        nxt.n = result[MSB];
        nxt.z = zero_w;
        nxt.c = c_w;
        nxt.v = v_w;
    end

    // Flag register: clear on reset, load on enable, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (upd_en) begin
            cur_q <= nxt;
        end
    end

    // Drive the flags out.
    always_comb begin
        flags_q = cur_q;
    end

endmodule

// File: rtl/flag_nzcv_chk.sv
// Module: flag_nzcv_chk
// Property checker for flag_nzcv_gen, bound to every instance of it.
// It relates each flag to the inputs of the cycle before.
module flag_nzcv_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_en,
    input logic [1:0]        op_cls,
    input logic [DATA_W-1:0] result,
    input logic              arith_co,
    input logic              sign_a,
    input logic              sign_b,
    input logic              sign_r,
    input logic              shift_co,
    input logic [3:0]        flags_q
);
    a_r1_neg_from_msb: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> flags_q[3] == $past(result[DATA_W-1]));

    a_r2_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> flags_q[2] == ($past(result) == '0));

    a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b00) |=> flags_q[1] == $past(arith_co));

    a_r4_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b01) |=> flags_q[1] == !$past(arith_co));

    a_r5_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b10) |=> flags_q[1] == $past(shift_co));

    a_r6_logic_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b11) |=> $stable(flags_q[1]));

    a_r7_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b00) |=>
        flags_q[0] == ($past(sign_a) == $past(sign_b) && $past(sign_r) != $past(sign_a)));

    a_r8_sub_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b01) |=>
        flags_q[0] == ($past(sign_a) != $past(sign_b) && $past(sign_r) != $past(sign_a)));

    a_r9_logic_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls[1]) |=> $stable(flags_q[0]));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(flags_q));

    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> flags_q == 4'b0000);

endmodule

bind flag_nzcv_gen flag_nzcv_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .op_cls   (op_cls),
    .result   (result),
    .arith_co (arith_co),
    .sign_a   (sign_a),
    .sign_b   (sign_b),
    .sign_r   (sign_r),
    .shift_co (shift_co),
    .flags_q  (flags_q)
);

// File: tb/flag_nzcv_gen_bench.sv
`timescale 1ns/1ps
module flag_nzcv_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_cls = 2'b00;
    logic [31:0] result = '0;
    logic        arith_co = 1'b0;
    logic        sign_a = 1'b0;
    logic        sign_b = 1'b0;
    logic        sign_r = 1'b0;
    logic        shift_co = 1'b0;
    logic [3:0]  flags_q;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Reference state: the flags the model expects after the next edge.
    bit    m_n = 0, m_z = 0, m_c = 0, m_v = 0;
    string m_tag = "R11";

    always #4 clk = ~clk;

    flag_nzcv_gen u_flag_nzcv_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .op_cls   (op_cls),
        .result   (result),
        .arith_co (arith_co),
        .sign_a   (sign_a),
        .sign_b   (sign_b),
        .sign_r   (sign_r),
        .shift_co (shift_co),
        .flags_q  (flags_q)
    );

    function automatic void cmp1(string what, string tag, bit act, bit exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s flag %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endfunction

    // Compare the DUT against the model, then apply new inputs and advance the model.
    task automatic step(input bit rst, input bit en, input int op, input logic [31:0] res,
                        input bit aco, input bit sa, input bit sb, input bit sr, input bit sco);
        @(negedge clk);
        cmp1("N", m_tag, flags_q[3], m_n);
        cmp1("Z", m_tag, flags_q[2], m_z);
        cmp1("C", m_tag, flags_q[1], m_c);
        cmp1("V", m_tag, flags_q[0], m_v);
        rst_n = !rst; upd_en = en; op_cls = 2'(op); result = res;
        arith_co = aco; sign_a = sa; sign_b = sb; sign_r = sr; shift_co = sco;
        if (rst) begin
            m_n = 0; m_z = 0; m_c = 0; m_v = 0; m_tag = "R11";
        end else if (!en) begin
            m_tag = "R10";
        end else begin
            m_n = res[31];
            m_z = (res == 32'd0);
            if (op == 0) begin
                m_c = aco;
                m_v = (sa == sb) && (sr != sa);
                m_tag = "R1/R2/R3/R7";
            end else if (op == 1) begin
                m_c = !aco;
                m_v = (sa != sb) && (sr != sa);
                m_tag = "R1/R2/R4/R8";
            end else if (op == 2) begin
                m_c = sco;
                m_tag = "R1/R2/R5/R9";
            end else begin
                m_tag = "R1/R2/R6/R9";
            end
        end
    endtask

    initial begin
        // Reset state (R11)
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 32'hFFFF_FFFF, 1, 1, 1, 0, 1);
        // R2 zero result on add with carry (R3), R7 no overflow
        step(0, 1, 0, 32'h0000_0000, 1, 1, 1, 1, 0);
        // R1 negative, R7 add overflow: positive + positive -> negative
        step(0, 1, 0, 32'h8000_0000, 0, 0, 0, 1, 0);
        // R9 plain-logical keeps C and V (R6), N and Z update
        step(0, 1, 3, 32'h0000_0001, 0, 1, 0, 0, 1);
        // R10 idle with wild inputs
        step(0, 0, 1, 32'h0000_0000, 1, 0, 1, 1, 1);
        step(0, 0, 2, 32'h8000_0000, 0, 1, 1, 1, 0);
        // R4 subtract with borrow -> C=0; R8 overflow: neg - pos -> pos
        step(0, 1, 1, 32'h7FFF_FFFF, 1, 1, 0, 0, 1);
        // R4 subtract no borrow -> C=1; R8 no overflow
        step(0, 1, 1, 32'h0000_0000, 0, 0, 0, 0, 0);
        // R5 shifted-logical takes shifter carry, V held (R9)
        step(0, 1, 2, 32'h0000_0100, 0, 1, 1, 0, 0);
        step(0, 1, 2, 32'hF000_0000, 0, 0, 0, 1, 1);
        // R6 plain-logical after shift keeps C=1
        step(0, 1, 3, 32'h0000_0000, 0, 0, 0, 0, 0);
        // R7 add overflow: negative + negative -> positive
        step(0, 1, 0, 32'h7FFF_FFFE, 1, 1, 1, 0, 0);
        step(0, 1, 3, 32'h0000_0010, 0, 0, 0, 1, 0);
        step(0, 0, 0, 32'h0000_0000, 0, 0, 0, 0, 0);
        // R11 reset in the middle of a run
        step(1, 1, 0, 32'h8000_0000, 1, 0, 0, 1, 1);
        step(0, 1, 3, 32'h8000_0000, 1, 0, 0, 1, 1);
        // Random traffic over all classes and enable states
        for (int i = 0; i < 3000; i++) begin
            step(($urandom_range(0, 199) == 0), ($urandom_range(0, 3) != 0),
                 int'($urandom_range(0, 3)),
                 ($urandom_range(0, 7) == 0) ? 32'd0 : 32'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule